// File: doc/BRIEF.md
# Direct-Mapped Translation Cache with Per-Access-Kind Tags

This block caches virtual-to-physical page translations in front of a page table walker. It is direct-mapped. The entry index comes from the virtual page number bits just above the page offset. Each entry holds one physical page number and three independent tags, one each for loads, stores and instruction fetches. A lookup compares only the tag of its own access kind. A page can therefore be cached as readable while a store to it still goes out to the walker.

A request carries a virtual address, an access kind, an access size and the privilege level. Responses come back one cycle after acceptance for hits and alignment faults. A miss raises a refill request that holds until the walker answers with a physical page number and six permission bits. The refill stores the page number in the entry. It then writes each of the three tags as valid only if the permission bits allow that kind at the captured privilege level, and invalidates the rest. A flush input invalidates every tag in one cycle and is meant to be pulsed whenever the page table base changes.

Top module: `xlt_tlb`

## Requirements
- R1: After reset, req_ready_o is 1, resp_valid_o and refill_valid_o are 0, badvaddr_o is 0, and every tag is invalid.
- R2: The entry index is vaddr[PG_SHIFT +: log2(ENTRIES)]. The tag is vaddr above PG_SHIFT. A refill for a different page at the same index replaces the older page, which then misses.
- R3: A request accepted while req_ready_o is 1 that hits gives resp_valid_o for one cycle on the next cycle, with resp_paddr_o = {stored page number, vaddr[PG_SHIFT-1:0]}, and raises no refill.
- R4: A miss raises refill_valid_o from the next cycle. refill_vaddr_o, refill_type_o (normalised kind) and refill_size_o stay stable, and req_ready_o stays 0, until walk_valid_i is seen.
- R5: walk_perm_i bits are [0] user read, [1] user write, [2] user execute, [3] supervisor read, [4] supervisor write, [5] supervisor execute. On walk_valid_i the entry's load, store and fetch tags become valid only where the matching read, write or execute bit for the captured privilege is 1. The other tags become invalid. The response follows one cycle later. It carries the translated address if the requested kind is allowed; otherwise it sets resp_denied_o with resp_paddr_o = 0.
- R6: Kind codes are 2'b00 load, 2'b01 store and 2'b10 fetch. Code 2'b11 uses the load tag. Each kind hits only on its own tag.
- R7: req_sup_i = 1 captured at acceptance selects the supervisor permission bits for the refill.
- R8: For loads and stores, req_size_i = n means 2^n bytes. If vaddr is not a multiple of that size, the response on the next cycle has resp_misalign_o = 1 and resp_paddr_o = 0, and badvaddr_o takes vaddr. No refill is raised and no tag changes. Fetches are never flagged.
- R9: flush_i invalidates every tag on the next edge. A request accepted in a flush cycle misses.
- R10: If flush_i and walk_valid_i come in the same cycle, the response is still delivered and the entry is left invalid.
- R11: A page whose virtual page number is all ones misses in an entry that has never been filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush_i | input | 1 | Invalidate all tags |
| req_valid_i | input | 1 | Lookup request |
| req_ready_o | output | 1 | Block can accept a request |
| req_vaddr_i | input | VA_W | Virtual address |
| req_type_i | input | 2 | Access kind code |
| req_size_i | input | 2 | log2 of access bytes |
| req_sup_i | input | 1 | Supervisor privilege |
| resp_valid_o | output | 1 | Response pulse |
| resp_paddr_o | output | PA_W | Physical address |
| resp_misalign_o | output | 1 | Alignment fault |
| resp_denied_o | output | 1 | Permission fault after refill |
| badvaddr_o | output | VA_W | Last misaligned address |
| refill_valid_o | output | 1 | Walk request pending |
| refill_vaddr_o | output | VA_W | Address to walk |
| refill_type_o | output | 2 | Normalised kind of the miss |
| refill_size_o | output | 2 | Size code of the miss |
| walk_valid_i | input | 1 | Walker answer |
| walk_ppn_i | input | PA_W-PG_SHIFT | Physical page number |
| walk_perm_i | input | 6 | Permission bits |

## Verification
The bench builds the block with ENTRIES = 8 and keeps 32-bit addresses with 13-bit pages. With only three index bits, two small addresses that differ only in bit 16 collide in one entry, so replacement can be exercised without large address sweeps. An address with an all-ones virtual page number falls in entry 7, where it is tested against the reset state. The permission mix covers per-kind refill masks under both privilege levels.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'b00,
    KIND_STORE = 2'b01,
    KIND_FETCH = 2'b10
  } kind_e;

  localparam int NUM_KINDS = 3;

  // Map a request code to the tag bank it uses; code 3 shares the load bank.
  function automatic logic [1:0] kind_of(input logic [1:0] code);
    if (code == 2'b10) return 2'd2;
    if (code == 2'b01) return 2'd1;
    return 2'd0;
  endfunction

  // Read/write/execute bit for a kind, user group low, supervisor group high.
  function automatic logic perm_ok(input logic [5:0] perm, input logic sup,
                                   input logic [1:0] kind);
    logic [2:0] b;
    b = {1'b0, kind} + (sup ? 3'd3 : 3'd0);
    return perm[b];
  endfunction

  // Nonzero low address bits under the size mask.
  function automatic logic is_misal(input logic [2:0] lo, input logic [1:0] sz);
    logic [2:0] m;
    m = 3'((4'd1 << sz) - 4'd1);
    return (lo & m) != 3'd0;
  endfunction

endpackage

// File: rtl/xlt_tag_bank.sv
module xlt_tag_bank #(
  parameter int ENTRIES = 256,
  parameter int IDX_W   = 8,
  parameter int VPN_W   = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [VPN_W-1:0] rd_vpn_i,
  output logic             match_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [VPN_W-1:0] wr_vpn_i,
  input  logic             wr_keep_i
);
  localparam int TAG_W = VPN_W + 1;
  localparam logic [TAG_W-1:0] TAG_NONE = '1;

  logic [TAG_W-1:0] tag_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tag_q[i] <= TAG_NONE;
    end else if (flush_i) begin
      for (int i = 0; i < ENTRIES; i++) tag_q[i] <= TAG_NONE;
    end else if (wr_en_i) begin
      tag_q[wr_idx_i] <= wr_keep_i ? {1'b0, wr_vpn_i} : TAG_NONE;
    end
  end

  // Valid tags carry a zero top bit, so the invalid pattern never matches.
  assign match_o = (tag_q[rd_idx_i] == {1'b0, rd_vpn_i});

  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> tag_q[rd_idx_i] == TAG_NONE);

  p_write_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !flush_i && wr_keep_i) |=>
      tag_q[$past(wr_idx_i)] == {1'b0, $past(wr_vpn_i)});

  p_write_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_keep_i) |=> tag_q[$past(wr_idx_i)] == TAG_NONE);

endmodule

// File: rtl/xlt_page_store.sv
module xlt_page_store #(
  parameter int ENTRIES = 256,
  parameter int IDX_W   = 8,
  parameter int PPN_W   = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [PPN_W-1:0] rd_ppn_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [PPN_W-1:0] wr_ppn_i
);
  logic [PPN_W-1:0] ppn_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ppn_q[i] <= '0;
    end else if (wr_en_i) begin
      ppn_q[wr_idx_i] <= wr_ppn_i;
    end
  end

  assign rd_ppn_o = ppn_q[rd_idx_i];

endmodule

// File: rtl/xlt_ctrl.sv
module xlt_ctrl
  import xlt_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int PA_W     = 32,
  parameter int PG_SHIFT = 13,
  parameter int IDX_W    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush_i,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [VA_W-1:0]          req_vaddr_i,
  input  logic [1:0]               req_type_i,
  input  logic [1:0]               req_size_i,
  input  logic                     req_sup_i,
  input  logic [NUM_KINDS-1:0]     match_i,
  input  logic [PA_W-PG_SHIFT-1:0] rd_ppn_i,
  output logic                     wr_en_o,
  output logic [IDX_W-1:0]         wr_idx_o,
  output logic [VA_W-PG_SHIFT-1:0] wr_vpn_o,
  output logic [NUM_KINDS-1:0]     wr_keep_o,
  output logic                     refill_valid_o,
  output logic [VA_W-1:0]          refill_vaddr_o,
  output logic [1:0]               refill_type_o,
  output logic [1:0]               refill_size_o,
  input  logic                     walk_valid_i,
  input  logic [PA_W-PG_SHIFT-1:0] walk_ppn_i,
  input  logic [5:0]               walk_perm_i,
  output logic                     resp_valid_o,
  output logic [PA_W-1:0]          resp_paddr_o,
  output logic                     resp_misalign_o,
  output logic                     resp_denied_o,
  output logic [VA_W-1:0]          badvaddr_o
);
  localparam int PPN_W = PA_W - PG_SHIFT;

  typedef enum logic {ST_IDLE, ST_WAIT} state_e;

  function automatic logic [PA_W-1:0] join_pa(input logic [PPN_W-1:0] ppn,
                                              input logic [PG_SHIFT-1:0] off);
    return {ppn, off};
  endfunction

  state_e          state_q;
  logic [VA_W-1:0] cur_vaddr_q;
  logic [1:0]      cur_kind_q;
  logic [1:0]      cur_size_q;
  logic            cur_sup_q;
  logic            resp_valid_q, resp_mis_q, resp_den_q;
  logic [PA_W-1:0] resp_paddr_q;
  logic [VA_W-1:0] badv_q;

  // Named internal events
  logic       acc_fire, lk_hit, lk_misalign, lk_miss, walk_done, walk_allow;
  logic [1:0] lk_kind;

  assign req_ready_o = (state_q == ST_IDLE);
  assign acc_fire    = req_valid_i && req_ready_o;
  assign lk_kind     = kind_of(req_type_i);
  assign lk_hit      = match_i[lk_kind] && !flush_i;
  assign lk_misalign = (lk_kind != 2'd2) && is_misal(req_vaddr_i[2:0], req_size_i);
  assign lk_miss     = acc_fire && !lk_hit && !lk_misalign;
  assign walk_done   = (state_q == ST_WAIT) && walk_valid_i;
  assign walk_allow  = perm_ok(walk_perm_i, cur_sup_q, cur_kind_q);

  assign wr_en_o  = walk_done;
  assign wr_idx_o = cur_vaddr_q[PG_SHIFT +: IDX_W];
  assign wr_vpn_o = cur_vaddr_q[VA_W-1:PG_SHIFT];

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_keep
    assign wr_keep_o[k] = perm_ok(walk_perm_i, cur_sup_q, 2'(k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      cur_vaddr_q  <= '0;
      cur_kind_q   <= '0;
      cur_size_q   <= '0;
      cur_sup_q    <= 1'b0;
      resp_valid_q <= 1'b0;
      resp_mis_q   <= 1'b0;
      resp_den_q   <= 1'b0;
      resp_paddr_q <= '0;
      badv_q       <= '0;
    end else begin
      resp_valid_q <= 1'b0;
      resp_mis_q   <= 1'b0;
      resp_den_q   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (acc_fire) begin
            cur_vaddr_q <= req_vaddr_i;
            cur_kind_q  <= lk_kind;
            cur_size_q  <= req_size_i;
            cur_sup_q   <= req_sup_i;
            if (lk_misalign) begin
              resp_valid_q <= 1'b1;
              resp_mis_q   <= 1'b1;
              resp_paddr_q <= '0;
              badv_q       <= req_vaddr_i;
            end else if (lk_hit) begin
              resp_valid_q <= 1'b1;
              resp_paddr_q <= join_pa(rd_ppn_i, req_vaddr_i[PG_SHIFT-1:0]);
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (walk_valid_i) begin
            state_q      <= ST_IDLE;
            resp_valid_q <= 1'b1;
            resp_den_q   <= !walk_allow;
            resp_paddr_q <= walk_allow ?
                            join_pa(walk_ppn_i, cur_vaddr_q[PG_SHIFT-1:0]) : '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign refill_valid_o  = (state_q == ST_WAIT);
  assign refill_vaddr_o  = cur_vaddr_q;
  assign refill_type_o   = cur_kind_q;
  assign refill_size_o   = cur_size_q;
  assign resp_valid_o    = resp_valid_q;
  assign resp_paddr_o    = resp_paddr_q;
  assign resp_misalign_o = resp_mis_q;
  assign resp_denied_o   = resp_den_q;
  assign badvaddr_o      = badv_q;

  p_hit_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && lk_hit && !lk_misalign) |=>
      resp_valid_o && !resp_denied_o && !refill_valid_o &&
      resp_paddr_o[PG_SHIFT-1:0] == $past(req_vaddr_i[PG_SHIFT-1:0]));

  p_miss_refill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |=> refill_valid_o && !resp_valid_o && refill_vaddr_o == $past(req_vaddr_i));

  p_refill_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_valid_o && !walk_valid_i) |=>
      refill_valid_o && !req_ready_o && $stable(refill_vaddr_o) && $stable(refill_type_o));

  p_walk_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> resp_valid_o && req_ready_o && !resp_misalign_o);

  p_misalign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && lk_misalign) |=>
      resp_valid_o && resp_misalign_o && !refill_valid_o &&
      badvaddr_o == $past(req_vaddr_i));

endmodule

// File: rtl/xlt_tlb.sv
module xlt_tlb
  import xlt_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int PA_W     = 32,
  parameter int PG_SHIFT = 13,
  parameter int ENTRIES  = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush_i,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [VA_W-1:0]          req_vaddr_i,
  input  logic [1:0]               req_type_i,
  input  logic [1:0]               req_size_i,
  input  logic                     req_sup_i,
  output logic                     resp_valid_o,
  output logic [PA_W-1:0]          resp_paddr_o,
  output logic                     resp_misalign_o,
  output logic                     resp_denied_o,
  output logic [VA_W-1:0]          badvaddr_o,
  output logic                     refill_valid_o,
  output logic [VA_W-1:0]          refill_vaddr_o,
  output logic [1:0]               refill_type_o,
  output logic [1:0]               refill_size_o,
  input  logic                     walk_valid_i,
  input  logic [PA_W-PG_SHIFT-1:0] walk_ppn_i,
  input  logic [5:0]               walk_perm_i
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int VPN_W = VA_W - PG_SHIFT;
  localparam int PPN_W = PA_W - PG_SHIFT;

  logic [IDX_W-1:0]     rd_idx, wr_idx;
  logic [VPN_W-1:0]     rd_vpn, wr_vpn;
  logic [PPN_W-1:0]     rd_ppn;
  logic [NUM_KINDS-1:0] match, wr_keep;
  logic                 wr_en;

  assign rd_idx = req_vaddr_i[PG_SHIFT +: IDX_W];
  assign rd_vpn = req_vaddr_i[VA_W-1:PG_SHIFT];

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_bank
    xlt_tag_bank #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .VPN_W(VPN_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush_i  (flush_i),
      .rd_idx_i (rd_idx),
      .rd_vpn_i (rd_vpn),
      .match_o  (match[k]),
      .wr_en_i  (wr_en),
      .wr_idx_i (wr_idx),
      .wr_vpn_i (wr_vpn),
      .wr_keep_i(wr_keep[k])
    );
  end

  xlt_page_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .PPN_W(PPN_W)) u_pages (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx_i(rd_idx),
    .rd_ppn_o(rd_ppn),
    .wr_en_i (wr_en),
    .wr_idx_i(wr_idx),
    .wr_ppn_i(walk_ppn_i)
  );

  xlt_ctrl #(.VA_W(VA_W), .PA_W(PA_W), .PG_SHIFT(PG_SHIFT), .IDX_W(IDX_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .flush_i        (flush_i),
    .req_valid_i    (req_valid_i),
    .req_ready_o    (req_ready_o),
    .req_vaddr_i    (req_vaddr_i),
    .req_type_i     (req_type_i),
    .req_size_i     (req_size_i),
    .req_sup_i      (req_sup_i),
    .match_i        (match),
    .rd_ppn_i       (rd_ppn),
    .wr_en_o        (wr_en),
    .wr_idx_o       (wr_idx),
    .wr_vpn_o       (wr_vpn),
    .wr_keep_o      (wr_keep),
    .refill_valid_o (refill_valid_o),
    .refill_vaddr_o (refill_vaddr_o),
    .refill_type_o  (refill_type_o),
    .refill_size_o  (refill_size_o),
    .walk_valid_i   (walk_valid_i),
    .walk_ppn_i     (walk_ppn_i),
    .walk_perm_i    (walk_perm_i),
    .resp_valid_o   (resp_valid_o),
    .resp_paddr_o   (resp_paddr_o),
    .resp_misalign_o(resp_misalign_o),
    .resp_denied_o  (resp_denied_o),
    .badvaddr_o     (badvaddr_o)
  );

endmodule

// File: tb/sim_xlt_tlb.sv
module sim_xlt_tlb;
  localparam int CLK_NS = 10;
  localparam int ENT    = 8;
  localparam int PGS    = 13;
  localparam int PPNW   = 32 - PGS;

  logic            clk = 1'b0, rst_n = 1'b0, flush_i = 1'b0;
  logic            req_valid_i = 1'b0, req_sup_i = 1'b0;
  logic [31:0]     req_vaddr_i = '0;
  logic [1:0]      req_type_i = '0, req_size_i = '0;
  logic            walk_valid_i = 1'b0;
  logic [PPNW-1:0] walk_ppn_i = '0;
  logic [5:0]      walk_perm_i = '0;
  logic            req_ready_o, resp_valid_o, resp_misalign_o, resp_denied_o, refill_valid_o;
  logic [31:0]     resp_paddr_o, badvaddr_o, refill_vaddr_o;
  logic [1:0]      refill_type_o, refill_size_o;

  xlt_tlb #(.ENTRIES(ENT)) u0 (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_vaddr_i(req_vaddr_i),
    .req_type_i(req_type_i), .req_size_i(req_size_i), .req_sup_i(req_sup_i),
    .resp_valid_o(resp_valid_o), .resp_paddr_o(resp_paddr_o),
    .resp_misalign_o(resp_misalign_o), .resp_denied_o(resp_denied_o),
    .badvaddr_o(badvaddr_o), .refill_valid_o(refill_valid_o),
    .refill_vaddr_o(refill_vaddr_o), .refill_type_o(refill_type_o),
    .refill_size_o(refill_size_o), .walk_valid_i(walk_valid_i),
    .walk_ppn_i(walk_ppn_i), .walk_perm_i(walk_perm_i)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_err = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Perm bits: [0]UR [1]UW [2]UX [3]SR [4]SW [5]SX
  typedef struct packed {
    logic [31:0]     va;
    logic [1:0]      ty;
    logic [1:0]      sz;
    logic            sup;
    logic            miss;
    logic [PPNW-1:0] ppn;
    logic [5:0]      perm;
    logic            mis;
    logic            den;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_2004, 2'b00, 2'd2, 1'b0, 1'b1, 19'h00ABC, 6'h03, 1'b0, 1'b0}, // R5 fill load+store
    '{32'h0000_2008, 2'b00, 2'd2, 1'b0, 1'b0, 19'h00ABC, 6'h00, 1'b0, 1'b0}, // R3
    '{32'h0000_2010, 2'b01, 2'd2, 1'b0, 1'b0, 19'h00ABC, 6'h00, 1'b0, 1'b0}, // R5 store tag kept
    '{32'h0000_2000, 2'b10, 2'd2, 1'b0, 1'b1, 19'h00ABC, 6'h07, 1'b0, 1'b0}, // R6 fetch own tag
    '{32'h0000_2020, 2'b00, 2'd2, 1'b0, 1'b0, 19'h00ABC, 6'h00, 1'b0, 1'b0}, // R3
    '{32'h0000_4000, 2'b00, 2'd3, 1'b0, 1'b1, 19'h00111, 6'h01, 1'b0, 1'b0}, // R5 read only
    '{32'h0000_4008, 2'b01, 2'd2, 1'b0, 1'b1, 19'h00111, 6'h01, 1'b0, 1'b1}, // R6 store misses, denied
    '{32'h0000_4000, 2'b00, 2'd2, 1'b0, 1'b0, 19'h00111, 6'h00, 1'b0, 1'b0}, // R3
    '{32'h0000_4010, 2'b11, 2'd2, 1'b0, 1'b0, 19'h00111, 6'h00, 1'b0, 1'b0}, // R6 code 3 -> load tag
    '{32'h0001_2004, 2'b00, 2'd2, 1'b0, 1'b1, 19'h00222, 6'h01, 1'b0, 1'b0}, // R2 alias fill
    '{32'h0000_2004, 2'b00, 2'd2, 1'b0, 1'b1, 19'h00ABC, 6'h03, 1'b0, 1'b0}, // R2 replaced -> miss
    '{32'h0000_6000, 2'b00, 2'd2, 1'b1, 1'b1, 19'h00333, 6'h01, 1'b0, 1'b1}, // R7 sup lacks SR
    '{32'h0000_6000, 2'b00, 2'd2, 1'b0, 1'b1, 19'h00333, 6'h01, 1'b0, 1'b0}, // R5 tags cleared
    '{32'h0000_6002, 2'b00, 2'd2, 1'b0, 1'b0, 19'h00000, 6'h00, 1'b1, 1'b0}, // R8
    '{32'h0000_6001, 2'b01, 2'd1, 1'b0, 1'b0, 19'h00000, 6'h00, 1'b1, 1'b0}, // R8
    '{32'h0000_6002, 2'b10, 2'd2, 1'b0, 1'b1, 19'h00333, 6'h05, 1'b0, 1'b0}, // R8 fetch not flagged
    '{32'h0000_6004, 2'b00, 2'd2, 1'b0, 1'b0, 19'h00333, 6'h00, 1'b0, 1'b0}, // R8 TLB untouched
    '{32'h0000_6003, 2'b00, 2'd0, 1'b0, 1'b0, 19'h00333, 6'h00, 1'b0, 1'b0}  // R8 byte never misaligned
  };

  task automatic run_req(input logic [31:0] va, input logic [1:0] ty, input logic [1:0] sz,
                         input logic sup, input logic miss, input logic [PPNW-1:0] ppn,
                         input logic [5:0] perm, input logic mis, input logic den,
                         input int waits, input logic fl_acc, input logic fl_walk,
                         input string tag);
    logic [31:0] exp_pa;
    @(negedge clk);
    chk({tag, " ready"}, {31'd0, req_ready_o}, 32'd1);
    req_valid_i = 1'b1; req_vaddr_i = va; req_type_i = ty; req_size_i = sz;
    req_sup_i = sup; flush_i = fl_acc;
    @(negedge clk);
    req_valid_i = 1'b0; flush_i = 1'b0;
    if (miss) begin
      chk({tag, " R4 refill_valid"}, {31'd0, refill_valid_o}, 32'd1);
      chk({tag, " R4 no early resp"}, {31'd0, resp_valid_o}, 32'd0);
      chk({tag, " R4 refill_vaddr"}, refill_vaddr_o, va);
      chk({tag, " R4 refill_type"}, {30'd0, refill_type_o}, {30'd0, (ty == 2'b11) ? 2'b00 : ty});
      chk({tag, " R4 refill_size"}, {30'd0, refill_size_o}, {30'd0, sz});
      for (int w = 0; w < waits; w++) begin
        @(negedge clk);
        chk({tag, " R4 hold"}, {30'd0, refill_valid_o, req_ready_o}, 32'd2);
        chk({tag, " R4 hold vaddr"}, refill_vaddr_o, va);
      end
      walk_valid_i = 1'b1; walk_ppn_i = ppn; walk_perm_i = perm; flush_i = fl_walk;
      @(negedge clk);
      walk_valid_i = 1'b0; flush_i = 1'b0;
    end else begin
      chk({tag, " no refill"}, {31'd0, refill_valid_o}, 32'd0);
    end
    exp_pa = (mis || den) ? 32'd0 : {ppn, va[PGS-1:0]};
    chk({tag, " resp_valid"}, {31'd0, resp_valid_o}, 32'd1);
    chk({tag, " flags mis/den"}, {30'd0, resp_misalign_o, resp_denied_o}, {30'd0, mis, den});
    chk({tag, " paddr"}, resp_paddr_o, exp_pa);
    if (mis) chk({tag, " R8 badvaddr"}, badvaddr_o, va);
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.mis) return "R8";
    if (v.miss) return "R5";
    return "R3";
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", {31'd0, req_ready_o}, 32'd1);
    chk("R1 resp_valid", {31'd0, resp_valid_o}, 32'd0);
    chk("R1 refill_valid", {31'd0, refill_valid_o}, 32'd0);
    chk("R1 badvaddr", badvaddr_o, 32'd0);

    // R11 all-ones page misses in an unfilled entry, then hits once filled
    run_req(32'hFFFF_E000, 2'b00, 2'd2, 1'b0, 1'b1, 19'h00007, 6'h01, 1'b0, 1'b0, 1, 1'b0, 1'b0, "R11 miss");
    run_req(32'hFFFF_E010, 2'b00, 2'd2, 1'b0, 1'b0, 19'h00007, 6'h00, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R11 hit");

    for (int i = 0; i < NV; i++)
      run_req(VECS[i].va, VECS[i].ty, VECS[i].sz, VECS[i].sup, VECS[i].miss, VECS[i].ppn,
              VECS[i].perm, VECS[i].mis, VECS[i].den, i % 3, 1'b0, 1'b0, tag_of(VECS[i]));

    // R7 supervisor read bit allows the load
    run_req(32'h0000_A000, 2'b00, 2'd2, 1'b1, 1'b1, 19'h00555, 6'h08, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R7 sup ok");

    // R9 standalone flush, then the filled page misses
    @(negedge clk); flush_i = 1'b1;
    @(negedge clk); flush_i = 1'b0;
    run_req(32'h0000_6004, 2'b00, 2'd2, 1'b0, 1'b1, 19'h00333, 6'h01, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R9 after flush");
    // R9 flush in the accept cycle forces a miss on a valid page
    run_req(32'h0000_6008, 2'b00, 2'd2, 1'b0, 1'b1, 19'h00333, 6'h01, 1'b0, 1'b0, 0, 1'b1, 1'b0, "R9 flush at accept");

    // R10 flush with walker answer: response delivered, entry left invalid
    run_req(32'h0000_8000, 2'b00, 2'd2, 1'b0, 1'b1, 19'h00444, 6'h01, 1'b0, 1'b0, 0, 1'b0, 1'b1, "R10 flush at walk");
    run_req(32'h0000_8000, 2'b00, 2'd2, 1'b0, 1'b1, 19'h00444, 6'h01, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R10 still invalid");
    run_req(32'h0000_8004, 2'b00, 2'd2, 1'b0, 1'b0, 19'h00444, 6'h00, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R10 refilled hit");

    @(negedge clk);
    chk("R3 resp is one pulse", {31'd0, resp_valid_o}, 32'd0);
    finish_run();
  end

endmodule